// File: doc/BRIEF.md
# Minimum-Mode Bus Cycle Controller

This block runs one external memory or I/O port transfer for a 16-bit processor whose 20-bit address shares pins with its 16-bit data. A single request supplies the address, the direction, a memory-or-port select, a word/byte size flag and write data. The block then walks through four clock states. The first state carries the address and a one-cycle address strobe. The middle states carry the read or write strobe. The last state closes the transfer. A slow target can stretch the transfer by holding its ready input low.

Byte lanes are chosen by an active-low high-byte enable together with address bit 0. A word access always presents an even address with both lanes enabled. A byte access enables only the lane that matches its address parity. Read data is steered back to the low byte for byte reads. A model of the external address latch is included, so the address stays visible after the shared pins switch over to data.

A request is taken only while the block is idle. The result comes back with a one-cycle done pulse, which is also the first cycle in which a new request can be taken.

Top module: `mmbus_cycle_ctrl`

## Requirements
- R1: While reset is high, and after it is released with no request pending, the outputs are: busy=0, done=0, ale=0, io_sel=0, bhe_n=1, rd_n=1, wr_n=1, ad_oe=0, ad_out=0, latched_addr=0 and rsp_rdata=0.
- R2: A request with req_valid=1 at a clock edge while idle starts state T1 in the next cycle. With ready high, T2, T3 and T4 follow, so busy is high for exactly four cycles. In the cycle after T4, done is high and busy is low.
- R3: ale is high only in T1, for one cycle. In T1, ad_oe=1 and ad_out carries the access address. The latch model captures that address and holds it on latched_addr from T2 until the next ale.
- R4: io_sel is 0 for a memory access and 1 for an I/O access. It is set from T1 and held unchanged through T4.
- R5: For an I/O access, address bits 19:16 are driven as 0 in T1, whatever was requested.
- R6: Lane encoding. A word access (req_word=1) drives address bit 0 as 0 and bhe_n=0. A byte access at an even address drives bit 0 as 0 and bhe_n=1. A byte access at an odd address drives bit 0 as 1 and bhe_n=0. bhe_n is held for the whole transfer.
- R7: rd_n is low for reads, and wr_n is low for writes, in T2, T3 and every wait state, and high at all other times. The two are never low together.
- R8: On a write, ad_oe=1 and ad_out[15:0] carries the write data from T2 to T4, with ad_out[19:16]=0. A word carries req_wdata unchanged. A byte carries req_wdata[7:0] on both lanes.
- R9: ready is sampled at the end of T3 and at the end of every wait state. Each low sample adds one wait state, with the strobe held low. The first high sample leads to T4.
- R10: A read captures bus_din at the end of T4 into rsp_rdata, shown with the done pulse. A word gives bus_din unchanged. An even byte gives {8'h00, bus_din[7:0]}. An odd byte gives {8'h00, bus_din[15:8]}.
- R11: done is a single-cycle pulse. req_valid is ignored while busy, so no second transfer (no ale) follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_addr | input | 20 | Requested address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O port, 0 = memory |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_wdata | input | 16 | Write data (a byte uses bits 7:0) |
| ready | input | 1 | Target ready, low inserts wait states |
| bus_din | input | 16 | Data the target drives on the shared pins |
| busy | output | 1 | Transfer in progress (T1 to T4) |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Steered read data |
| ale | output | 1 | Address strobe, high in T1 |
| io_sel | output | 1 | Memory (0) or I/O (1) indicator |
| bhe_n | output | 1 | Active-low high-byte enable |
| ad_out | output | 20 | Value driven on the shared address/data pins |
| ad_oe | output | 1 | Output enable for ad_out |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| latched_addr | output | 20 | Address held by the external latch model |

## Verification
Directed transfers cover word, even-byte and odd-byte accesses, for both reads and writes. These tell apart the three lane encodings and the read and write lane steering, because the target returns different values on its two bytes. Memory and I/O transfers use addresses whose upper nibble is non-zero, which exposes any missing I/O address masking. Zero, one and three wait states show whether ready is sampled in the correct state and whether the strobe is held. A request raised mid-transfer shows whether the idle-only acceptance rule holds.

// File: rtl/mmbus_pkg.sv
package mmbus_pkg;

    localparam int ADDR_W    = 20;
    localparam int DATA_W    = 16;
    localparam int IO_ADDR_W = 16;
    localparam int LANE_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              io;
        logic              word;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic strobe_phase(input bus_state_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
    endfunction

    function automatic logic data_phase(input bus_state_e s);
        return strobe_phase(s) || (s == ST_T4);
    endfunction

endpackage

// File: rtl/mmbus_seq.sv
module mmbus_seq
    import mmbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       ready,
    output bus_state_e state
);

    bus_state_e state_q;
    bus_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = ready ? ST_T4 : ST_TW;
            ST_TW:   state_d = ready ? ST_T4 : ST_TW;
            ST_T4:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/mmbus_lane.sv
module mmbus_lane #(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int IOW = 16,
    parameter int LW  = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          io,
    input  logic          word,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] addr_drv,
    output logic          bhe_n,
    output logic [DW-1:0] wbus,
    output logic [DW-1:0] rdata
);

    localparam int NLANE = DW / LW;

    always_comb begin
        addr_drv = addr;
        if (io)   addr_drv[AW-1:IOW] = '0;
        if (word) addr_drv[0] = 1'b0;
    end

    assign bhe_n = word ? 1'b0 : ~addr[0];

    for (genvar g = 0; g < NLANE; g++) begin : g_wlane
        assign wbus[g*LW +: LW] = word ? wdata[g*LW +: LW] : wdata[LW-1:0];
    end

    always_comb begin
        rdata = '0;
        if (word)         rdata = bus_din;
        else if (addr[0]) rdata[LW-1:0] = bus_din[LW +: LW];
        else              rdata[LW-1:0] = bus_din[LW-1:0];
    end

endmodule

// File: rtl/mmbus_latch.sv
module mmbus_latch #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          le,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (le) q <= d;
    end

endmodule

// File: rtl/mmbus_cycle_ctrl.sv
module mmbus_cycle_ctrl
    import mmbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ale,
    output logic              io_sel,
    output logic              bhe_n,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] latched_addr
);

    localparam int PAD_W = ADDR_W - DATA_W;

    bus_state_e        state;
    bus_req_t          req_q;
    logic              accept;
    logic [ADDR_W-1:0] addr_drv;
    logic              lane_bhe_n;
    logic [DATA_W-1:0] wbus;
    logic [DATA_W-1:0] rd_steer;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic              strobe;
    logic              wdrive;

    assign accept = req_valid && (state == ST_IDLE);

    mmbus_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .ready (ready),
        .state (state)
    );

    mmbus_lane #(
        .AW  (ADDR_W),
        .DW  (DATA_W),
        .IOW (IO_ADDR_W),
        .LW  (LANE_W)
    ) u_lane (
        .addr     (req_q.addr),
        .io       (req_q.io),
        .word     (req_q.word),
        .wdata    (req_q.wdata),
        .bus_din  (bus_din),
        .addr_drv (addr_drv),
        .bhe_n    (lane_bhe_n),
        .wbus     (wbus),
        .rdata    (rd_steer)
    );

    mmbus_latch #(.AW(ADDR_W)) u_latch (
        .clk (clk),
        .rst (rst),
        .le  (ale),
        .d   (ad_out),
        .q   (latched_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                req_q.addr  <= req_addr;
                req_q.write <= req_write;
                req_q.io    <= req_io;
                req_q.word  <= req_word;
                req_q.wdata <= req_wdata;
            end
            done_q <= (state == ST_T4);
            if (state == ST_T4 && !req_q.write) rdata_q <= rd_steer;
        end
    end

    assign busy   = (state != ST_IDLE);
    assign ale    = (state == ST_T1);
    assign strobe = strobe_phase(state);
    assign wdrive = req_q.write && data_phase(state);
    assign rd_n   = !(strobe && !req_q.write);
    assign wr_n   = !(strobe && req_q.write);
    assign ad_oe  = ale || wdrive;
    assign io_sel = busy && req_q.io;
    assign bhe_n  = busy ? lane_bhe_n : 1'b1;

    always_comb begin
        if (ale)         ad_out = addr_drv;
        else if (wdrive) ad_out = {{PAD_W{1'b0}}, wbus};
        else             ad_out = '0;
    end

    assign done      = done_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/mmbus_checker.sv
module mmbus_checker (
    input logic        clk,
    input logic        rst,
    input logic        ready,
    input logic        busy,
    input logic        done,
    input logic        ale,
    input logic        io_sel,
    input logic        bhe_n,
    input logic [19:0] ad_out,
    input logic        ad_oe,
    input logic        rd_n,
    input logic        wr_n,
    input logic [19:0] latched_addr
);

    assert_ale_single_R3: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ale |=> $stable(latched_addr));

    assert_iosel_held_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(io_sel));

    assert_io_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (ale && io_sel) |-> (ad_out[19:16] == 4'h0));

    assert_even_low_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (ale && bhe_n) |-> !ad_out[0]);

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_no_strobe_in_t1_R7: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));

    assert_write_driven_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    assert_wait_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !ready) |=> !rd_n);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind mmbus_cycle_ctrl mmbus_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ready        (ready),
    .busy         (busy),
    .done         (done),
    .ale          (ale),
    .io_sel       (io_sel),
    .bhe_n        (bhe_n),
    .ad_out       (ad_out),
    .ad_oe        (ad_oe),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .latched_addr (latched_addr)
);

// File: tb/mmbus_cycle_ctrl_tb.sv
module mmbus_cycle_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        ready = 1'b1;
    logic [15:0] bus_din = '0;
    logic        busy, done, ale, io_sel, bhe_n, ad_oe, rd_n, wr_n;
    logic [15:0] rsp_rdata;
    logic [19:0] ad_out, latched_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mmbus_cycle_ctrl u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_addr (req_addr),
        .req_write (req_write), .req_io (req_io), .req_word (req_word),
        .req_wdata (req_wdata), .ready (ready), .bus_din (bus_din),
        .busy (busy), .done (done), .rsp_rdata (rsp_rdata), .ale (ale),
        .io_sel (io_sel), .bhe_n (bhe_n), .ad_out (ad_out), .ad_oe (ad_oe),
        .rd_n (rd_n), .wr_n (wr_n), .latched_addr (latched_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !ale && !io_sel && bhe_n && rd_n && wr_n && !ad_oe,
            "R1", "control idle in reset",
            {busy, done, ale, io_sel, bhe_n, rd_n, wr_n, ad_oe}, 8'b0000_1110);
        chk(ad_out == 0 && latched_addr == 0 && rsp_rdata == 0, "R1", "data zero in reset",
            {ad_out[15:0], rsp_rdata}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !ale && rd_n && wr_n && bhe_n, "R1", "idle after release",
            {busy, ale, rd_n, wr_n, bhe_n}, 5'b00111);
    endtask

    task automatic txn(input logic [19:0] a, input bit wr, input bit io, input bit word,
                       input logic [15:0] wd, input logic [15:0] dev,
                       input int nwait, input bit poke);
        logic [19:0] ea;
        logic        eb;
        logic [15:0] ewb;
        logic [15:0] erd;
        ea = a;
        if (io)   ea[19:16] = 4'h0;
        if (word) ea[0] = 1'b0;
        eb  = word ? 1'b0 : ~a[0];
        ewb = word ? wd : {wd[7:0], wd[7:0]};
        erd = word ? dev : (a[0] ? {8'h00, dev[15:8]} : {8'h00, dev[7:0]});

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_io = io;
        req_word = word; req_wdata = wd; bus_din = dev; ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale && ad_oe && busy, "R3", "T1 ale/oe/busy", {ale, ad_oe, busy}, 3'b111);
        chk(ad_out == ea, "R3", "T1 address", ad_out, ea);
        if (io) chk(ad_out[19:16] == 4'h0, "R5", "I/O upper nibble", ad_out[19:16], 0);
        chk(io_sel == io, "R4", "T1 io_sel", io_sel, io);
        chk(bhe_n == eb && ad_out[0] == ea[0], "R6", "T1 lane code",
            {bhe_n, ad_out[0]}, {eb, ea[0]});
        chk(rd_n && wr_n, "R7", "no strobe in T1", {rd_n, wr_n}, 2'b11);

        @(negedge clk);
        if (poke) req_valid = 1'b1;
        chk(!ale && busy, "R3", "T2 ale low", {ale, busy}, 2'b01);
        chk(latched_addr == ea, "R3", "latched address", latched_addr, ea);
        chk(rd_n == wr && wr_n == !wr, "R7", "T2 strobe", {rd_n, wr_n}, {wr, !wr});
        if (wr) chk(ad_oe && ad_out == {4'h0, ewb}, "R8", "T2 write data", ad_out, {4'h0, ewb});
        else    chk(!ad_oe, "R8", "read releases bus", ad_oe, 0);

        @(negedge clk);
        req_valid = 1'b0;
        ready = (nwait == 0);
        chk(busy && rd_n == wr && wr_n == !wr, "R7", "T3 strobe", {busy, rd_n, wr_n}, {1'b1, wr, !wr});
        chk(bhe_n == eb && io_sel == io, "R6", "T3 lane code held", {bhe_n, io_sel}, {eb, io});

        for (int k = 1; k <= nwait; k++) begin
            @(negedge clk);
            ready = (k == nwait);
            chk(busy && !ale && rd_n == wr && wr_n == !wr, "R9", "wait state strobe held",
                {busy, ale, rd_n, wr_n}, {2'b10, wr, !wr});
            chk(latched_addr == ea, "R3", "latch held in wait", latched_addr, ea);
        end

        @(negedge clk);
        ready = 1'b1;
        chk(busy && rd_n && wr_n && !done, "R9", "T4 after ready", {busy, rd_n, wr_n, done}, 4'b1110);
        chk(io_sel == io, "R4", "T4 io_sel held", io_sel, io);
        if (wr) chk(ad_oe && ad_out == {4'h0, ewb}, "R8", "T4 write data", ad_out, {4'h0, ewb});

        @(negedge clk);
        chk(done && !busy, "R2", "done after four states plus waits", {done, busy}, 2'b10);
        if (!wr) chk(rsp_rdata == erd, "R10", "read data steering", rsp_rdata, erd);
        bus_din = 16'h0000;

        @(negedge clk);
        chk(!done, "R11", "done single pulse", done, 0);
        chk(!ale && !busy, "R11", "request while busy ignored", {ale, busy}, 2'b00);
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        // R2 R10: memory word read, no waits
        txn(20'hA1234, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 0, 1'b0);
        // R6 R10: even byte read
        txn(20'h30010, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h5AC3, 0, 1'b0);
        // R6 R10: odd byte read with one wait
        txn(20'h30011, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h5AC3, 1, 1'b0);
        // R6: word request at odd address forced even
        txn(20'h40007, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h1357, 0, 1'b0);
        // R8: word write
        txn(20'h7FFFE, 1'b1, 1'b0, 1'b1, 16'hCAFE, 16'h0000, 0, 1'b0);
        // R8 R6: odd byte write with waits
        txn(20'h12345, 1'b1, 1'b0, 1'b0, 16'h00A5, 16'h0000, 3, 1'b0);
        // R4 R5: I/O read, upper nibble masked, waits
        txn(20'hF00F0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h9966, 2, 1'b0);
        // R4 R5 R11: I/O word write with request raised mid-transfer
        txn(20'hE8002, 1'b1, 1'b1, 1'b1, 16'h4321, 16'h0000, 0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule